// File: doc/BRIEF.md
# Branch and Subroutine-Call Sequencer

This block turns a single branch-family instruction word into the next program counter and into a short ordered run of micro-cycles. A micro-cycle is an internal idle cycle, an instruction prefetch, or a stack write. The block also evaluates the branch condition from the four flags.

The branch family covers three cases: the conditional branch, the always-taken branch and the call-to-subroutine. One condition code that would otherwise mean "never" is given a second meaning: it is the call. A call pushes a two-word return address before it refills the queue.

The decoder raises `start_i` together with the opcode, the prefetched extension word, the flags, the program counter and the stack pointer. The block captures all of them at that edge. It then emits one micro-cycle per clock and pulses `done_o` with the resolved program counter.

Top module: `branch_seq`

## Requirements
- R1: A `start_i` whose opcode has bits 15:12 different from 0x6 is ignored: no micro-cycle is emitted and `done_o` stays low.
- R2: The condition code is bits 11:8 of the opcode. Flags are `flags_i` = {N,Z,V,C}. The branch is taken under these rules:
  - code 0: always
  - 2: !C&!Z
  - 3: C|Z
  - 4: !C
  - 5: C
  - 6: !Z
  - 7: Z
  - 8: !V
  - 9: V
  - 10: !N
  - 11: N
  - 12: N==V
  - 13: N!=V
  - 14: !Z&(N==V)
  - 15: Z|(N!=V)
- R3: The displacement is the signed low byte of the opcode. When that byte is zero, the displacement is the signed 16-bit `ext_i` instead.
- R4: `pc_i` is the opcode address plus 4. A taken branch or a call resolves to `pc_i` + displacement - 2.
- R5: `uop_o` encodings are: 0 for idle, 1 for prefetch, 2 for stack write. A taken branch with a code other than 1 emits idle, prefetch, prefetch.
- R6: A branch that is not taken and has a byte displacement emits idle, idle, prefetch, and resolves to `pc_i` - 2.
- R7: A branch that is not taken and has a word displacement emits idle, idle, prefetch, prefetch, and resolves to `pc_i`.
- R8: Condition code 1 is a call. It is taken whatever the flags are, and it emits idle, stack write, stack write, prefetch, prefetch.
- R9: The call's return address is `pc_i` - 2 for a byte displacement and `pc_i` for a word displacement. The first stack write carries bits 31:16 of that address to `sp_i` - 4. The second carries bits 15:0 to `sp_i` - 2. The value of `sp_i` is the one captured at start.
- R10: The first micro-cycle appears in the cycle after the start edge, and one follows per cycle. `done_o` pulses for one cycle after the last step, and `next_pc_o` holds the result during that pulse.
- R11: A `start_i` raised while a sequence is running is ignored. The running sequence and its result are not changed.
- R12: After reset, `uop_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request with an instruction word |
| opcode_i | input | 16 | Instruction word |
| ext_i | input | 16 | Extension word from the prefetch queue |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| pc_i | input | ADDR_W | Program counter at decode (opcode address + 4) |
| sp_i | input | ADDR_W | Current stack pointer |
| uop_valid_o | output | 1 | A micro-cycle is being emitted |
| uop_o | output | 2 | Micro-cycle kind: 0 idle, 1 prefetch, 2 stack write |
| waddr_o | output | ADDR_W | Stack write address during a stack write |
| wdata_o | output | 16 | Stack write data during a stack write |
| done_o | output | 1 | One-cycle pulse after the last micro-cycle |
| next_pc_o | output | ADDR_W | Resolved program counter, valid with done_o |

## Verification
The hardest case to reach is the call whose return address crosses a 64 KiB boundary. Only that case makes the two pushed halves differ in their upper word, and it shows whether the halves are ordered and addressed correctly. The stimulus sets `pc_i` just past such a boundary and uses a byte displacement, so the return address falls back below the boundary. A second directed case raises `start_i` with a call opcode in the middle of a running sequence. It then checks that neither the micro-cycle run nor the resolved counter changes. A sweep over all condition codes, all flag values and both displacement sizes covers the condition table.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;
  localparam int unsigned OP_W   = 16;
  localparam int unsigned LONG_W = 32;
  localparam int unsigned STEP_W = 3;
  localparam logic [3:0]  FAMILY  = 4'h6;
  localparam logic [3:0]  CC_CALL = 4'h1;

  typedef enum logic [1:0] {
    UOP_IDLE     = 2'd0,
    UOP_PREFETCH = 2'd1,
    UOP_SWRITE   = 2'd2
  } uop_e;

  typedef enum logic [1:0] {
    SEQ_TAKEN   = 2'd0,
    SEQ_NT_BYTE = 2'd1,
    SEQ_NT_WORD = 2'd2,
    SEQ_CALL    = 2'd3
  } seq_e;

  function automatic logic [STEP_W-1:0] seq_len(seq_e s);
    case (s)
      SEQ_TAKEN:   seq_len = 3'd3;
      SEQ_NT_BYTE: seq_len = 3'd3;
      SEQ_NT_WORD: seq_len = 3'd4;
      default:     seq_len = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval (
  input  logic [3:0] cc_i,
  input  logic [3:0] flags_i,
  output logic       take_o
);
  logic n, z, v, c;
  assign {n, z, v, c} = flags_i;

  always_comb begin
    case (cc_i)
      4'd0:    take_o = 1'b1;
      4'd1:    take_o = 1'b0;  // "never"; call handled by caller
      4'd2:    take_o = !c && !z;
      4'd3:    take_o = c || z;
      4'd4:    take_o = !c;
      4'd5:    take_o = c;
      4'd6:    take_o = !z;
      4'd7:    take_o = z;
      4'd8:    take_o = !v;
      4'd9:    take_o = v;
      4'd10:   take_o = !n;
      4'd11:   take_o = n;
      4'd12:   take_o = (n == v);
      4'd13:   take_o = (n != v);
      4'd14:   take_o = !z && (n == v);
      default: take_o = z || (n != v);
    endcase
  end
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [15:0]       opcode_i,
  input  logic [15:0]       ext_i,
  input  logic              take_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic [ADDR_W-1:0] ret_o,
  output logic              word_o
);
  localparam int unsigned BYTE_PAD = ADDR_W - 8;
  localparam int unsigned WORD_PAD = ADDR_W - 16;
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] disp;

  assign word_o = (opcode_i[7:0] == 8'h00);
  assign disp   = word_o ? {{WORD_PAD{ext_i[15]}}, ext_i}
                         : {{BYTE_PAD{opcode_i[7]}}, opcode_i[7:0]};
  // fall-through address equals the return address
  assign ret_o     = word_o ? pc_i : pc_i - TWO;
  assign next_pc_o = take_i ? pc_i + disp - TWO : ret_o;
endmodule

// File: rtl/branch_step_gen.sv
module branch_step_gen
  import branch_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  seq_e              seq_i,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_o,
  output uop_e              uop_o,
  output logic              last_o
);
  seq_e              seq_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q;

  assign last_o = busy_q && (step_q == seq_len(seq_q) - 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      seq_q  <= SEQ_TAKEN;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      step_q <= '0;
      seq_q  <= seq_i;
    end else if (busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        step_q <= step_q + 3'd1;
    end
  end

  always_comb begin
    uop_o = UOP_IDLE;
    case (seq_q)
      SEQ_TAKEN:   uop_o = (step_q == 3'd0) ? UOP_IDLE : UOP_PREFETCH;
      SEQ_NT_BYTE,
      SEQ_NT_WORD: uop_o = (step_q < 3'd2) ? UOP_IDLE : UOP_PREFETCH;
      default: begin
        if (step_q == 3'd0)      uop_o = UOP_IDLE;
        else if (step_q < 3'd3)  uop_o = UOP_SWRITE;
        else                     uop_o = UOP_PREFETCH;
      end
    endcase
  end

  assign busy_o = busy_q;
  assign step_o = step_q;
endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import branch_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       opcode_i,
  input  logic [15:0]       ext_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              uop_valid_o,
  output logic [1:0]        uop_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [15:0]       wdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam logic [ADDR_W-1:0] FOUR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] TWO  = ADDR_W'(2);

  logic              is_call, cond_take, take, is_word, launch, busy, last;
  logic [ADDR_W-1:0] next_pc_d, ret_d;
  logic [ADDR_W-1:0] next_pc_q, ret_q, sp_q;
  logic [LONG_W-1:0] ret_long;
  logic [STEP_W-1:0] step;
  logic              done_q;
  seq_e              seq_sel;
  uop_e              uop;

  assign is_call = (opcode_i[11:8] == CC_CALL);
  assign take    = is_call || cond_take;
  assign launch  = start_i && !busy && (opcode_i[15:12] == FAMILY);

  branch_cond_eval u_cond (
    .cc_i    (opcode_i[11:8]),
    .flags_i (flags_i),
    .take_o  (cond_take)
  );

  branch_target_calc #(.ADDR_W(ADDR_W)) u_target (
    .pc_i      (pc_i),
    .opcode_i  (opcode_i),
    .ext_i     (ext_i),
    .take_i    (take),
    .next_pc_o (next_pc_d),
    .ret_o     (ret_d),
    .word_o    (is_word)
  );

  always_comb begin
    if (is_call)      seq_sel = SEQ_CALL;
    else if (take)    seq_sel = SEQ_TAKEN;
    else if (is_word) seq_sel = SEQ_NT_WORD;
    else              seq_sel = SEQ_NT_BYTE;
  end

  branch_step_gen u_steps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .seq_i    (seq_sel),
    .busy_o   (busy),
    .step_o   (step),
    .uop_o    (uop),
    .last_o   (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_q <= '0;
      ret_q     <= '0;
      sp_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last;
      if (launch) begin
        next_pc_q <= next_pc_d;
        ret_q     <= ret_d;
        sp_q      <= sp_i;
      end
    end
  end

  assign ret_long = LONG_W'(ret_q);

  // high word pushed first to the lower address
  always_comb begin
    waddr_o = '0;
    wdata_o = '0;
    if (busy && uop == UOP_SWRITE) begin
      if (step == 3'd1) begin
        waddr_o = sp_q - FOUR;
        wdata_o = ret_long[31:16];
      end else begin
        waddr_o = sp_q - TWO;
        wdata_o = ret_long[15:0];
      end
    end
  end

  assign uop_valid_o = busy;
  assign uop_o       = busy ? uop : UOP_IDLE;
  assign done_o      = done_q;
  assign next_pc_o   = next_pc_q;
endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [15:0]       opcode_i,
  input logic              uop_valid_o,
  input logic [1:0]        uop_o,
  input logic              done_o
);
  assert_family_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uop_valid_o && start_i && opcode_i[15:12] != 4'h6) |=> !uop_valid_o);

  assert_first_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uop_valid_o) |-> uop_o == 2'd0);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(uop_valid_o) |-> done_o);

  assert_prefetch_tail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_o == 2'd1) |=> ((uop_valid_o && uop_o == 2'd1) || done_o));

  assert_swrite_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_o == 2'd2) |=> (uop_valid_o && uop_o != 2'd0));
endmodule

bind branch_seq branch_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .opcode_i    (opcode_i),
  .uop_valid_o (uop_valid_o),
  .uop_o       (uop_o),
  .done_o      (done_o)
);

// File: tb/branch_seq_tb.sv
module branch_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [15:0] ext_i = '0;
  logic [3:0]  flags_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] sp_i = '0;
  logic        uop_valid_o;
  logic [1:0]  uop_o;
  logic [31:0] waddr_o;
  logic [15:0] wdata_o;
  logic        done_o;
  logic [31:0] next_pc_o;

  int n_chk = 0;
  int n_err = 0;
  bit fin = 1'b0;

  always #5 clk_i = ~clk_i;

  branch_seq #(.ADDR_W(32)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .opcode_i(opcode_i),
    .ext_i(ext_i), .flags_i(flags_i), .pc_i(pc_i), .sp_i(sp_i),
    .uop_valid_o(uop_valid_o), .uop_o(uop_o), .waddr_o(waddr_o),
    .wdata_o(wdata_o), .done_o(done_o), .next_pc_o(next_pc_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // R2 condition table
  function automatic bit cond_ok(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, v, c;
    {n, z, v, c} = f;
    case (cc)
      4'd0: return 1;  4'd1: return 1;  // code 1 is the call: always taken
      4'd2: return !c && !z;  4'd3: return c || z;
      4'd4: return !c;        4'd5: return c;
      4'd6: return !z;        4'd7: return z;
      4'd8: return !v;        4'd9: return v;
      4'd10: return !n;       4'd11: return n;
      4'd12: return n == v;   4'd13: return n != v;
      4'd14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic run_case(input logic [15:0] op, input logic [15:0] ext,
                          input logic [3:0] fl, input logic [31:0] pc,
                          input logic [31:0] sp);
    int exp_uop[5];
    int len;
    bit call, word, tk;
    logic [31:0] disp, exp_pc, ret;
    string rq;
    call = (op[11:8] == 4'd1);
    word = (op[7:0] == 8'h00);
    tk   = cond_ok(op[11:8], fl);
    disp = word ? {{16{ext[15]}}, ext} : {{24{op[7]}}, op[7:0]};  // R3
    ret  = word ? pc : pc - 32'd2;
    exp_pc = tk ? pc + disp - 32'd2 : ret;                        // R4
    if (call) begin
      len = 5; exp_uop = '{0, 2, 2, 1, 1}; rq = "R8";
    end else if (tk) begin
      len = 3; exp_uop = '{0, 1, 1, 0, 0}; rq = "R5";
    end else if (word) begin
      len = 4; exp_uop = '{0, 0, 1, 1, 0}; rq = "R7";
    end else begin
      len = 3; exp_uop = '{0, 0, 1, 0, 0}; rq = "R6";
    end
    @(negedge clk_i);
    opcode_i = op; ext_i = ext; flags_i = fl; pc_i = pc; sp_i = sp; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      check(uop_valid_o === 1'b1, {rq, " R10 valid"}, 32'(uop_valid_o), 32'd1);
      check(uop_o === 2'(exp_uop[i]), {rq, " uop"}, 32'(uop_o), 32'(exp_uop[i]));
      if (call && i == 1) begin
        check(wdata_o === ret[31:16], "R9 high word", 32'(wdata_o), 32'(ret[31:16]));
        check(waddr_o === sp - 32'd4, "R9 high addr", waddr_o, sp - 32'd4);
      end
      if (call && i == 2) begin
        check(wdata_o === ret[15:0], "R9 low word", 32'(wdata_o), 32'(ret[15:0]));
        check(waddr_o === sp - 32'd2, "R9 low addr", waddr_o, sp - 32'd2);
      end
      check(done_o === 1'b0, "R10 early done", 32'(done_o), 32'd0);
      @(negedge clk_i);
    end
    check(done_o === 1'b1 && uop_valid_o === 1'b0, "R10 done", 32'(done_o), 32'd1);
    check(next_pc_o === exp_pc, {rq, " R2 R3 R4 next pc"}, next_pc_o, exp_pc);
    @(negedge clk_i);
    check(done_o === 1'b0, "R10 done pulse width", 32'(done_o), 32'd0);
  endtask

  task automatic test_reset();
    check(uop_valid_o === 1'b0, "R12 valid", 32'(uop_valid_o), 32'd0);
    check(done_o === 1'b0, "R12 done", 32'(done_o), 32'd0);
  endtask

  task automatic test_cond_sweep();  // R2, R5, R6, R7
    for (int cc = 0; cc < 16; cc++)
      for (int fl = 0; fl < 16; fl++) begin
        run_case({4'h6, 4'(cc), 8'hF0}, 16'h7777, 4'(fl), 32'h0000_4000, 32'h0000_8000);
        run_case({4'h6, 4'(cc), 8'h00}, 16'h0124, 4'(fl), 32'h0000_4000, 32'h0000_8000);
      end
  endtask

  task automatic test_word_far();  // R3 negative word displacement
    run_case(16'h6000, 16'h8000, 4'h0, 32'h0012_0000, 32'h0000_9000);
    run_case(16'h6700, 16'hFFFE, 4'h4, 32'h0000_1000, 32'h0000_9000);
  endtask

  task automatic test_call_cross();  // R8 R9 return address across 64 KiB
    run_case(16'h6110, 16'h0000, 4'h0, 32'h0003_0000, 32'h0001_0000);
    run_case(16'h6100, 16'hF000, 4'hF, 32'h0003_0000, 32'h0000_2002);
  endtask

  task automatic test_non_family();  // R1
    @(negedge clk_i);
    opcode_i = 16'h4E75; start_i = 1'b1;
    @(negedge clk_i);
    opcode_i = 16'h7001;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(uop_valid_o === 1'b0, "R1 no uop", 32'(uop_valid_o), 32'd0);
      check(done_o === 1'b0, "R1 no done", 32'(done_o), 32'd0);
      @(negedge clk_i);
    end
  endtask

  task automatic test_busy_start();  // R11
    @(negedge clk_i);
    opcode_i = 16'h6010; flags_i = 4'h0; pc_i = 32'h1000; sp_i = 32'h2000; start_i = 1'b1;
    @(negedge clk_i);
    check(uop_o === 2'd0 && uop_valid_o, "R11 step0", 32'(uop_o), 32'd0);
    opcode_i = 16'h6100; ext_i = 16'h0400; pc_i = 32'h5000;
    @(negedge clk_i);
    check(uop_o === 2'd1 && uop_valid_o, "R11 step1", 32'(uop_o), 32'd1);
    start_i = 1'b0;
    @(negedge clk_i);
    check(uop_o === 2'd1 && uop_valid_o, "R11 step2", 32'(uop_o), 32'd1);
    @(negedge clk_i);
    check(done_o === 1'b1, "R11 done", 32'(done_o), 32'd1);
    check(next_pc_o === 32'h100E, "R11 pc", next_pc_o, 32'h100E);
    @(negedge clk_i);
    check(uop_valid_o === 1'b0, "R11 no relaunch", 32'(uop_valid_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_non_family();
    test_cond_sweep();
    test_word_far();
    test_call_cross();
    test_busy_start();
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!fin) begin
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule